// File: doc/BRIEF.md
# Lane Divergence Mask Stack

This block tracks which lanes of a lockstep thread group are enabled while the group runs structured if/else/endif code. Every lane holds one enable bit. A lane whose bit is clear still sees each instruction, but it must not commit any result. The front end of the pipeline decodes the control operations and presents each one together with the per-lane condition vector. The block answers with the enable mask for the next instruction, and with a pulse that tells the front end a body has no enabled lane and can be jumped over.

A divergent `if` pushes the taken lanes onto a bounded stack of masks. An `else` swaps the top entry for the lanes of the enclosing mask that did not take the branch. An `endif` pops the top entry, so the lanes reconverge on the enclosing mask. A branch that the front end marks as uniform pushes nothing. It only reports whether the body is skipped, so no stack entry is spent on the large share of branches that never diverge. Any push attempted while the stack is full, and any pop or swap attempted at the base entry, is refused and reported for one cycle.

Top module: `dms_top`

## Requirements
- R1: After reset the enable mask is all ones (the base entry) and `body_skip`, `stk_ovf` and `stk_unf` are low.
- R2: An operation is accepted when `op_vld` is high. The value of `op_kind` selects it: 2'b01 = if, 2'b10 = else, 2'b11 = endif, 2'b00 = no operation. Every effect of an operation appears at the outputs one clock after it is accepted.
- R3: A divergent if (`op_uni` low) pushes an entry equal to the current mask ANDed with `lane_cond`, and that entry becomes the enable mask.
- R4: Divergent ifs nest. With lanes 0 and 1 taking the outer branch and lane 0 alone taking the inner one, the mask goes from all ones to 0x3 and then to 0x1.
- R5: An else replaces the top entry with the entry beneath it ANDed with the inverse of `lane_cond`. Presenting the inner condition again in the example of R4 gives 0x2.
- R6: An endif pops the top entry and restores the enclosing mask. After every open level is closed, the mask is all ones again.
- R7: A uniform if (`op_uni` high) leaves the stack and the mask unchanged. It pulses `body_skip` exactly when no enabled lane has its condition bit set. A later endif at the base therefore reports underflow.
- R8: A divergent if whose pushed entry is all zeros still pushes, and it pulses `body_skip`.
- R9: An else whose resulting mask is all zeros pulses `body_skip`.
- R10: A divergent if issued when DEPTH entries are already in use (base plus DEPTH-1 pushes) pulses `stk_ovf` and leaves the mask and the depth unchanged.
- R11: An else or endif issued at the base entry pulses `stk_unf` and leaves the mask all ones.
- R12: `body_skip`, `stk_ovf` and `stk_unf` are single-cycle pulses, all low in the cycle after a clock with `op_vld` low. An idle cycle leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_vld | input | 1 | A control operation is presented this cycle |
| op_kind | input | 2 | Operation code: 01 if, 10 else, 11 endif, 00 none |
| op_uni | input | 1 | The if is known to be uniform across the group |
| lane_cond | input | LANES | Per-lane branch condition |
| act_mask | output | LANES | Current lane enable mask (top entry) |
| body_skip | output | 1 | Pulse: the body just entered has no enabled lane |
| stk_ovf | output | 1 | Pulse: push refused, stack full |
| stk_unf | output | 1 | Pulse: pop or swap refused, stack at base |

## Verification
The bench replays the nested four-lane walk and checks the mask after every step. A design that takes the else mask from the current top instead of the enclosing entry would give 0x0 rather than 0x2 there. It fills the stack to exactly DEPTH entries and then pushes once more. An off-by-one full test would either refuse the last legal push or overwrite memory past the end, and the mask seen on the way back down would be wrong. It closes a uniform if with an endif at the base, which exposes any push that should not have happened. It also checks that an if with an empty entry still pushes, because a design that skipped that push would pop the enclosing level at the matching endif.

// File: rtl/dms_pkg.sv
package dms_pkg;

  // operation codes presented by the decoder
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_IF    = 2'b01,
    OP_ELSE  = 2'b10,
    OP_ENDIF = 2'b11
  } op_e;

  // stack action chosen by the controller
  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_PUSH = 2'b01,
    ACT_SWAP = 2'b10,
    ACT_POP  = 2'b11
  } act_e;

endpackage

// File: rtl/dms_ctrl.sv
module dms_ctrl
  import dms_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic             op_vld,
  input  logic [1:0]       op_kind,
  input  logic             op_uni,
  input  logic [LANES-1:0] cond,
  input  logic [LANES-1:0] top,
  input  logic [LANES-1:0] parent,
  input  logic             at_base,
  input  logic             at_full,
  output act_e             act,
  output logic [LANES-1:0] wr_mask,
  output logic             skip_nxt,
  output logic             ovf_nxt,
  output logic             unf_nxt
);

  // lanes that enter the then-path
  function automatic logic [LANES-1:0] then_lanes(input logic [LANES-1:0] cur,
                                                  input logic [LANES-1:0] c);
    return cur & c;
  endfunction

  // lanes that enter the else-path
  function automatic logic [LANES-1:0] else_lanes(input logic [LANES-1:0] encl,
                                                  input logic [LANES-1:0] c);
    return encl & ~c;
  endfunction

  function automatic logic no_lane(input logic [LANES-1:0] m);
    return (m == '0);
  endfunction

  logic [LANES-1:0] taken;
  logic [LANES-1:0] other;

  assign taken = then_lanes(top, cond);
  assign other = else_lanes(parent, cond);

  always_comb begin
    act      = ACT_HOLD;
    wr_mask  = top;
    skip_nxt = 1'b0;
    ovf_nxt  = 1'b0;
    unf_nxt  = 1'b0;
    if (op_vld) begin
      unique case (op_e'(op_kind))
        OP_IF: begin
          if (op_uni) begin
            skip_nxt = no_lane(taken);
          end else if (at_full) begin
            ovf_nxt = 1'b1;
          end else begin
            act      = ACT_PUSH;
            wr_mask  = taken;
            skip_nxt = no_lane(taken);
          end
        end
        OP_ELSE: begin
          if (at_base) begin
            unf_nxt = 1'b1;
          end else begin
            act      = ACT_SWAP;
            wr_mask  = other;
            skip_nxt = no_lane(other);
          end
        end
        OP_ENDIF: begin
          if (at_base) unf_nxt = 1'b1;
          else         act     = ACT_POP;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dms_stack.sv
module dms_stack
  import dms_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  act_e             act,
  input  logic [LANES-1:0] wr_mask,
  output logic [LANES-1:0] top,
  output logic [LANES-1:0] parent,
  output logic             at_base,
  output logic             at_full
);

  localparam int PW = (DEPTH > 2) ? $clog2(DEPTH) : 1;

  logic [PW-1:0]                 sp;
  logic [PW-1:0]                 sp_up;
  logic [PW-1:0]                 sp_dn;
  logic [DEPTH-1:0][LANES-1:0]   ent;

  assign sp_up = sp + PW'(1);
  assign sp_dn = sp - PW'(1);

  // base entry: every lane enabled, never written
  assign ent[0] = '1;

  for (genvar g = 1; g < DEPTH; g++) begin : g_ent
    logic [LANES-1:0] q;
    logic             wr_here;
    assign wr_here = ((act == ACT_PUSH) && (sp_up == PW'(g))) ||
                     ((act == ACT_SWAP) && (sp == PW'(g)));
    always_ff @(posedge clk) begin
      if (!rst_n)       q <= '0;
      else if (wr_here) q <= wr_mask;
    end
    assign ent[g] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0;
    end else begin
      case (act)
        ACT_PUSH: sp <= sp_up;
        ACT_POP:  sp <= sp_dn;
        default:  sp <= sp;
      endcase
    end
  end

  assign at_base = (sp == '0);
  assign at_full = (sp == PW'(DEPTH - 1));
  assign top     = ent[sp];
  assign parent  = at_base ? ent[0] : ent[sp_dn];

endmodule

// File: rtl/dms_top.sv
module dms_top
  import dms_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_vld,
  input  logic [1:0]       op_kind,
  input  logic             op_uni,
  input  logic [LANES-1:0] lane_cond,
  output logic [LANES-1:0] act_mask,
  output logic             body_skip,
  output logic             stk_ovf,
  output logic             stk_unf
);

  act_e             act;
  logic [LANES-1:0] wr_mask;
  logic [LANES-1:0] top;
  logic [LANES-1:0] parent;
  logic             at_base;
  logic             at_full;
  logic             skip_nxt;
  logic             ovf_nxt;
  logic             unf_nxt;

  // named events for the checker
  logic ev_push;
  logic ev_swap;
  logic ev_pop;
  logic ev_refuse;

  dms_ctrl #(.LANES(LANES)) u_ctrl (
    .op_vld   (op_vld),
    .op_kind  (op_kind),
    .op_uni   (op_uni),
    .cond     (lane_cond),
    .top      (top),
    .parent   (parent),
    .at_base  (at_base),
    .at_full  (at_full),
    .act      (act),
    .wr_mask  (wr_mask),
    .skip_nxt (skip_nxt),
    .ovf_nxt  (ovf_nxt),
    .unf_nxt  (unf_nxt)
  );

  dms_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .wr_mask (wr_mask),
    .top     (top),
    .parent  (parent),
    .at_base (at_base),
    .at_full (at_full)
  );

  assign ev_push   = (act == ACT_PUSH);
  assign ev_swap   = (act == ACT_SWAP);
  assign ev_pop    = (act == ACT_POP);
  assign ev_refuse = ovf_nxt | unf_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      body_skip <= 1'b0;
      stk_ovf   <= 1'b0;
      stk_unf   <= 1'b0;
    end else begin
      body_skip <= skip_nxt;
      stk_ovf   <= ovf_nxt;
      stk_unf   <= unf_nxt;
    end
  end

  assign act_mask = top;

endmodule

// File: rtl/dms_chk.sv
module dms_chk #(
  parameter int LANES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_vld,
  input logic [1:0]       op_kind,
  input logic             op_uni,
  input logic [LANES-1:0] act_mask,
  input logic             body_skip,
  input logic             stk_ovf,
  input logic             stk_unf,
  input logic             ev_push,
  input logic             ev_pop,
  input logic             ev_refuse
);

  AST_PUSH_NARROWS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |=> ((act_mask & ~$past(act_mask)) == '0));                       // R3

  AST_POP_WIDENS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop |=> (($past(act_mask) & ~act_mask) == '0));                        // R6

  AST_UNI_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && op_kind == 2'b01 && op_uni) |=> $stable(act_mask));           // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |-> $stable(act_mask));                                          // R10

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    stk_unf |-> (act_mask == '1));                                           // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_vld |=> (!body_skip && !stk_ovf && !stk_unf && $stable(act_mask)));  // R12

  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stk_ovf, stk_unf}));                                           // R12

  AST_REFUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_refuse |=> (stk_ovf || stk_unf));                                     // R10

endmodule

bind dms_top dms_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_vld    (op_vld),
  .op_kind   (op_kind),
  .op_uni    (op_uni),
  .act_mask  (act_mask),
  .body_skip (body_skip),
  .stk_ovf   (stk_ovf),
  .stk_unf   (stk_unf),
  .ev_push   (ev_push),
  .ev_pop    (ev_pop),
  .ev_refuse (ev_refuse)
);

// File: tb/sim_dms_top.sv
module sim_dms_top;

  localparam int L = 32;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_vld = 1'b0;
  logic [1:0]   op_kind = 2'b00;
  logic         op_uni = 1'b0;
  logic [L-1:0] lane_cond = '0;
  logic [L-1:0] act_mask;
  logic         body_skip;
  logic         stk_ovf;
  logic         stk_unf;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench reference stack, written from the requirements
  logic [L-1:0] ref_stk [D];
  int           ref_sp;

  always #2.5 clk = ~clk;

  dms_top #(.LANES(L), .DEPTH(D)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_vld    (op_vld),
    .op_kind   (op_kind),
    .op_uni    (op_uni),
    .lane_cond (lane_cond),
    .act_mask  (act_mask),
    .body_skip (body_skip),
    .stk_ovf   (stk_ovf),
    .stk_unf   (stk_unf)
  );

  task automatic chk(input string req, input string what,
                     input logic [L-1:0] got, input logic [L-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // issue one operation, predict its effect, check after the edge
  task automatic issue(input logic [1:0] kind, input logic uni,
                       input logic [L-1:0] c, input string req);
    logic [L-1:0] nm;
    logic e_skip, e_ovf, e_unf;
    e_skip = 1'b0; e_ovf = 1'b0; e_unf = 1'b0;
    case (kind)
      2'b01: begin
        nm = ref_stk[ref_sp] & c;
        if (uni) e_skip = (nm == '0);
        else if (ref_sp == D - 1) e_ovf = 1'b1;
        else begin
          ref_sp++;
          ref_stk[ref_sp] = nm;
          e_skip = (nm == '0);
        end
      end
      2'b10: begin
        if (ref_sp == 0) e_unf = 1'b1;
        else begin
          nm = ref_stk[ref_sp-1] & ~c;
          ref_stk[ref_sp] = nm;
          e_skip = (nm == '0);
        end
      end
      2'b11: begin
        if (ref_sp == 0) e_unf = 1'b1;
        else ref_sp--;
      end
      default: ;
    endcase
    @(negedge clk);
    op_vld = 1'b1; op_kind = kind; op_uni = uni; lane_cond = c;
    @(negedge clk);
    op_vld = 1'b0; op_kind = 2'b00; op_uni = 1'b0;
    chk(req, "mask", act_mask, ref_stk[ref_sp]);
    chk(req, "skip", L'(body_skip), L'(e_skip));
    chk(req, "ovf",  L'(stk_ovf),   L'(e_ovf));
    chk(req, "unf",  L'(stk_unf),   L'(e_unf));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ref_sp = 0;
    ref_stk[0] = '1;
    @(negedge clk);
    chk("R1", "reset mask", act_mask, '1);
    chk("R1", "reset flags", L'({body_skip, stk_ovf, stk_unf}), '0);
  endtask

  task automatic t_nested();
    issue(2'b01, 1'b0, 32'h0000_0003, "R4");
    chk("R3", "outer push", act_mask, 32'h0000_0003);
    issue(2'b01, 1'b0, 32'h0000_0001, "R4");
    chk("R4", "inner push", act_mask, 32'h0000_0001);
    issue(2'b10, 1'b0, 32'h0000_0001, "R5");
    chk("R5", "inner else", act_mask, 32'h0000_0002);
    issue(2'b11, 1'b0, '0, "R6");
    chk("R6", "inner endif", act_mask, 32'h0000_0003);
    issue(2'b10, 1'b0, 32'h0000_0003, "R5");
    chk("R5", "outer else", act_mask, 32'hFFFF_FFFC);
    issue(2'b11, 1'b0, '0, "R6");
    chk("R6", "reconverged", act_mask, '1);
  endtask

  task automatic t_divergent_mix();
    issue(2'b01, 1'b0, 32'hA5A5_0F0F, "R3");
    issue(2'b01, 1'b0, 32'hFF00_FF00, "R3");
    chk("R3", "and of two", act_mask, 32'hA500_0F00);
    issue(2'b10, 1'b0, 32'hFF00_FF00, "R5");
    chk("R5", "else mix", act_mask, 32'h00A5_000F);
    issue(2'b11, 1'b0, '0, "R6");
    issue(2'b11, 1'b0, '0, "R6");
  endtask

  task automatic t_uniform();
    issue(2'b01, 1'b1, '1, "R7");
    chk("R7", "uniform taken mask", act_mask, '1);
    issue(2'b01, 1'b1, '0, "R7");
    chk("R7", "uniform skip", L'(body_skip), L'(1));
    issue(2'b11, 1'b0, '0, "R7");
    chk("R7", "no push left", L'(stk_unf), L'(1));
  endtask

  task automatic t_empty_bodies();
    issue(2'b01, 1'b0, 32'h0000_00F0, "R8");
    issue(2'b01, 1'b0, 32'h0000_000F, "R8");
    chk("R8", "empty if skip", L'(body_skip), L'(1));
    issue(2'b10, 1'b0, 32'h0000_000F, "R9");
    chk("R9", "else all lanes", act_mask, 32'h0000_00F0);
    issue(2'b11, 1'b0, '0, "R8");
    chk("R8", "empty if popped once", act_mask, 32'h0000_00F0);
    issue(2'b10, 1'b0, '1, "R9");
    chk("R9", "empty else skip", L'(body_skip), L'(1));
    issue(2'b11, 1'b0, '0, "R9");
  endtask

  task automatic t_overflow();
    for (int i = 1; i < D; i++) issue(2'b01, 1'b0, ~(L'(1) << i), "R10");
    chk("R10", "last legal push no ovf", L'(stk_ovf), L'(0));
    issue(2'b01, 1'b0, 32'h0000_0001, "R10");
    chk("R10", "overflow pulse", L'(stk_ovf), L'(1));
    for (int i = 1; i < D; i++) issue(2'b11, 1'b0, '0, "R10");
    chk("R10", "back at base", act_mask, '1);
  endtask

  task automatic t_underflow();
    issue(2'b10, 1'b0, 32'h1234_5678, "R11");
    chk("R11", "else at base", L'(stk_unf), L'(1));
    issue(2'b11, 1'b0, '0, "R11");
    chk("R11", "mask kept", act_mask, '1);
  endtask

  task automatic t_idle();
    issue(2'b01, 1'b0, 32'h0F0F_0F0F, "R2");
    issue(2'b01, 1'b1, '0, "R12");
    @(negedge clk);
    chk("R12", "skip dropped", L'(body_skip), L'(0));
    chk("R12", "idle mask", act_mask, 32'h0F0F_0F0F);
    issue(2'b00, 1'b0, '0, "R2");
    chk("R2", "no-op keeps mask", act_mask, 32'h0F0F_0F0F);
    issue(2'b11, 1'b0, '0, "R2");
  endtask

  initial begin
    t_reset();
    t_nested();
    t_divergent_mix();
    t_uniform();
    t_empty_bodies();
    t_overflow();
    t_underflow();
    t_idle();
    t_reset();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule